// File: doc/BRIEF.md
# Dual-Device Task-File Register Bank

This block holds the byte-wide command and parameter registers of a disk interface for a pair of drives sharing one cable: a primary drive (slot 0) and a secondary drive (slot 1), each of which may or may not be fitted. A host reaches the registers through a small address-decoded port. Every host write lands in each fitted drive in the same cycle. A host read is answered by one drive only, chosen by the drive-select bit of the drive/head register. A 16-bit data port drains a per-drive sector buffer word by word while that drive's data-request flag is up.

An external command engine owns everything past register access. It receives a one-cycle command strobe per drive together with the command byte and the features byte. It writes back status and error values, fills the sector buffers through a side port and opens a read transfer of a chosen word count. Each drive also runs a small state machine for the power-on and software-reset handshake. The states are DS_PWRON, DS_IDLE and DS_SRST. DS_PWRON always goes to DS_IDLE on the first clock after reset is released. DS_IDLE goes to DS_SRST when the reset bit is written as 1. DS_SRST goes back to DS_IDLE when that bit is written as 0.

Top module: `tf_pair_bank`

## Requirements
- R1: After reset each fitted drive ends power-on in DS_IDLE with status 0x40 (ready bit 6 set, busy bit 7 clear), every parameter register zero, and no command strobe or warning raised.
- R2: A host write is applied in the same cycle to every fitted drive. The address map is: 0 data, 1 error (read) / features (write), 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 status (read) / command (write), 8 alternate status (read) / device control (write). Data-port writes are ignored.
- R3: With both drives fitted, reads come from slot 1 when bit 4 of the drive/head register is 1 and from slot 0 otherwise. With one drive fitted, that drive answers every read.
- R4: A status or alternate-status read returns 0x00 when drive/head bit 4 differs from the answering drive's identity. Other registers are returned unchanged.
- R5: Slot 0 has identity 0. Slot 1 has identity 1 when slot 0 is fitted and identity 0 when it is not.
- R6: A data-port read while the answering drive's data-request flag (status bit 3) is clear returns 0 and changes nothing.
- R7: A transfer of N words (1 to the buffer depth) sets the data-request flag. Each data-port read then returns buffer words 0, 1, 2, ... in turn. The flag clears on the read of the N-th word.
- R8: A command write raises a one-cycle strobe for each fitted drive whose identity equals drive/head bit 4. A drive that is not selected strobes only for command 0x90. The strobe carries the command byte.
- R9: A command write raises a one-cycle protocol warning for each fitted drive whose busy bit (7) or data-request bit (3) is set, except for command 0x08.
- R10: A read of addresses 9 to 15, or any read with no drive fitted, returns 0 with the read-error flag set.
- R11: Writing device control with bit 2 set in DS_IDLE enters DS_SRST, sets busy and drops any data request. Writing it with bit 2 clear in DS_SRST returns to DS_IDLE with busy clear, ready set and error 0x01.
- R12: An engine update replaces a drive's status bits other than bit 3, and its error register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dev_present | input | 2 | Fitted flag per slot, held static between resets |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Host write byte |
| host_rvalid | output | 1 | Read result valid, one cycle after a read strobe |
| host_rdata | output | 16 | Read result |
| host_rerr | output | 1 | Read addressed nothing |
| fill_we | input | 1 | Sector buffer fill strobe |
| fill_dev | input | 1 | Slot the fill targets |
| fill_addr | input | 8 | Buffer word index |
| fill_word | input | 16 | Buffer word |
| eng_upd | input | 1 | Engine status/error update strobe |
| eng_dev | input | 1 | Slot targeted by the engine |
| eng_status | input | 8 | New status (bit 3 ignored) |
| eng_error | input | 8 | New error value |
| eng_xfer | input | 1 | Open a data-port transfer |
| eng_words | input | 9 | Transfer length in words |
| cmd_pulse | output | 2 | Command strobe per slot |
| cmd_code | output | 8 | Last command byte written |
| cmd_feat | output | 8 | Features byte of the answering drive |
| proto_warn | output | 2 | Protocol warning per slot |

## Verification
A host read strobe sampled at a rising edge puts its result on the read outputs at that same edge. The result holds until the next read, so the bench samples it 1 ns after that edge. Command strobes and protocol warnings are registered from the command write and last only the cycle after the write's edge. Each write task therefore captures them 1 ns after its own edge, before they fall. Engine updates, fills and transfer openings take effect at their edge, and every task drives on the falling edge, so each read that follows sees the new state without any extra wait.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

    localparam int N_DEV = 2;
    localparam int REG_W = 8;

    // host register addresses
    localparam logic [3:0] A_DATA    = 4'd0;
    localparam logic [3:0] A_ERRFEAT = 4'd1;
    localparam logic [3:0] A_SCNT    = 4'd2;
    localparam logic [3:0] A_SNUM    = 4'd3;
    localparam logic [3:0] A_CYLL    = 4'd4;
    localparam logic [3:0] A_CYLH    = 4'd5;
    localparam logic [3:0] A_DEVHD   = 4'd6;
    localparam logic [3:0] A_STATCMD = 4'd7;
    localparam logic [3:0] A_ALTCTL  = 4'd8;

    // bit positions
    localparam int SB_BSY   = 7;
    localparam int SB_DRDY  = 6;
    localparam int SB_DRQ   = 3;
    localparam int SEL_BIT  = 4;
    localparam int CTL_SRST = 2;

    localparam logic [REG_W-1:0] OP_DIAG   = 8'h90;
    localparam logic [REG_W-1:0] OP_DEVRST = 8'h08;
    localparam logic [REG_W-1:0] DIAG_PASS = 8'h01;
    localparam logic [REG_W-1:0] STAT_RDY  = 8'h40;
    localparam logic [REG_W-1:0] STAT_PWR  = 8'h80;

    typedef enum logic [1:0] {
        DS_PWRON = 2'd0,
        DS_IDLE  = 2'd1,
        DS_SRST  = 2'd2
    } dev_state_t;

    typedef struct packed {
        logic [REG_W-1:0] cyl_lo;
        logic [REG_W-1:0] cyl_hi;
        logic [REG_W-1:0] sec_num;
        logic [REG_W-1:0] sec_cnt;
        logic [REG_W-1:0] feat;
        logic [REG_W-1:0] dev_hd;
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] error;
    } task_file_t;

endpackage

// File: rtl/tfb_sector_buf.sv
module tfb_sector_buf #(
    parameter  int WORD_W = 16,
    parameter  int DEPTH  = 256,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tfb_xfer_ctr.sv
module tfb_xfer_ctr #(
    parameter  int DEPTH = 256,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] words,
    input  logic             pop,
    input  logic             abort,
    output logic             drq,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [CNT_W-1:0] MAX_WORDS = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_cnt;
    logic             drq_q;
    logic [PTR_W-1:0] ptr_q;

    // a request longer than the buffer is cut to the buffer depth
    assign load_cnt = (words > MAX_WORDS) ? MAX_WORDS : words;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            drq_q <= 1'b0;
            ptr_q <= '0;
        end else if (abort) begin
            cnt_q <= '0;
            drq_q <= 1'b0;
        end else if (start && (words != '0)) begin
            cnt_q <= load_cnt;
            drq_q <= 1'b1;
            ptr_q <= '0;
        end else if (pop && drq_q) begin
            cnt_q <= cnt_q - ONE;
            ptr_q <= ptr_q + PTR_W'(1);
            if (cnt_q == ONE) begin
                drq_q <= 1'b0;
            end
        end
    end

    assign drq = drq_q;
    assign ptr = ptr_q;

endmodule

// File: rtl/tfb_dev.sv
module tfb_dev
    import tfb_pkg::*;
#(
    parameter  int WORD_W = 16,
    parameter  int DEPTH  = 256,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              present,
    input  logic              my_id,
    input  logic              wr,
    input  logic [3:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              pop,
    input  logic              fill_we,
    input  logic [PTR_W-1:0]  fill_addr,
    input  logic [WORD_W-1:0] fill_word,
    input  logic              upd,
    input  logic [REG_W-1:0]  upd_status,
    input  logic [REG_W-1:0]  upd_error,
    input  logic              xfer,
    input  logic [CNT_W-1:0]  xfer_words,
    output task_file_t        tf,
    output logic              drq,
    output logic [WORD_W-1:0] word,
    output logic              cmd_pulse,
    output logic              warn
);

    dev_state_t       state_q, state_d;
    logic             wr_en, ctl_wr, cmd_wr, srst_bit;
    logic             enter_srst, leave_srst, leave_pwron;
    logic             selected, exec, hazard;
    logic [REG_W-1:0] cyl_lo_q, cyl_hi_q, sec_num_q, sec_cnt_q;
    logic [REG_W-1:0] feat_q, dev_hd_q, stat_q, error_q;
    logic             cmd_pulse_q, warn_q;
    logic [PTR_W-1:0] rd_ptr;

    assign wr_en    = present && wr;
    assign ctl_wr   = wr_en && (addr == A_ALTCTL);
    assign cmd_wr   = wr_en && (addr == A_STATCMD);
    assign srst_bit = wdata[CTL_SRST];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_PWRON: state_d = DS_IDLE;
            DS_IDLE:  if (ctl_wr && srst_bit)  state_d = DS_SRST;
            DS_SRST:  if (ctl_wr && !srst_bit) state_d = DS_IDLE;
            default:  state_d = DS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_PWRON;
        end else begin
            state_q <= state_d;
        end
    end

    assign leave_pwron = (state_q == DS_PWRON);
    assign enter_srst  = (state_q == DS_IDLE) && (state_d == DS_SRST);
    assign leave_srst  = (state_q == DS_SRST) && (state_d == DS_IDLE);

    // parameter registers written by the host
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyl_lo_q  <= '0;
            cyl_hi_q  <= '0;
            sec_num_q <= '0;
            sec_cnt_q <= '0;
            feat_q    <= '0;
            dev_hd_q  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CYLL:    cyl_lo_q  <= wdata;
                A_CYLH:    cyl_hi_q  <= wdata;
                A_SNUM:    sec_num_q <= wdata;
                A_SCNT:    sec_cnt_q <= wdata;
                A_ERRFEAT: feat_q    <= wdata;
                A_DEVHD:   dev_hd_q  <= wdata;
                default:   ;
            endcase
        end
    end

    // status / error outputs of the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q  <= STAT_PWR;
            error_q <= '0;
        end else if (leave_pwron) begin
            stat_q  <= STAT_RDY;
        end else if (enter_srst) begin
            stat_q[SB_BSY] <= 1'b1;
        end else if (leave_srst) begin
            stat_q[SB_BSY]  <= 1'b0;
            stat_q[SB_DRDY] <= 1'b1;
            error_q         <= DIAG_PASS;
        end else if (upd) begin
            stat_q          <= upd_status;
            stat_q[SB_DRQ]  <= 1'b0;
            error_q         <= upd_error;
        end
    end

    // command strobe and protocol warning
    assign selected = (dev_hd_q[SEL_BIT] == my_id);
    assign exec     = cmd_wr && (selected || (wdata == OP_DIAG));
    assign hazard   = cmd_wr && (stat_q[SB_BSY] || drq) && (wdata != OP_DEVRST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_pulse_q <= 1'b0;
            warn_q      <= 1'b0;
        end else begin
            cmd_pulse_q <= exec;
            warn_q      <= hazard;
        end
    end

    tfb_xfer_ctr #(.DEPTH(DEPTH)) u_xfer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (xfer),
        .words (xfer_words),
        .pop   (pop),
        .abort (enter_srst),
        .drq   (drq),
        .ptr   (rd_ptr)
    );

    tfb_sector_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (fill_we),
        .waddr (fill_addr),
        .wdata (fill_word),
        .raddr (rd_ptr),
        .rdata (word)
    );

    always_comb begin
        tf         = '0;
        tf.cyl_lo  = cyl_lo_q;
        tf.cyl_hi  = cyl_hi_q;
        tf.sec_num = sec_num_q;
        tf.sec_cnt = sec_cnt_q;
        tf.feat    = feat_q;
        tf.dev_hd  = dev_hd_q;
        tf.status  = stat_q;
        tf.status[SB_DRQ] = drq;
        tf.error   = error_q;
    end

    assign cmd_pulse = cmd_pulse_q;
    assign warn      = warn_q;

endmodule

// File: rtl/tfb_read_mux.sv
module tfb_read_mux
    import tfb_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [N_DEV-1:0]             present,
    input  logic [N_DEV-1:0]             ids,
    input  task_file_t [N_DEV-1:0]       tf,
    input  logic [N_DEV-1:0]             drq,
    input  logic [N_DEV-1:0][WORD_W-1:0] words,
    input  logic [3:0]                   addr,
    output logic                         sel,
    output logic [WORD_W-1:0]            data,
    output logic                         err
);

    task_file_t       cur;
    logic             id_match;
    logic [REG_W-1:0] stat_vis;

    // answering slot
    always_comb begin
        if (present == 2'b11) begin
            sel = tf[1].dev_hd[SEL_BIT];
        end else begin
            sel = present[1] && !present[0];
        end
    end

    assign cur      = tf[sel];
    assign id_match = (cur.dev_hd[SEL_BIT] == ids[sel]);
    assign stat_vis = id_match ? cur.status : '0;

    always_comb begin
        data = '0;
        err  = 1'b0;
        if (present == '0) begin
            err = 1'b1;
        end else begin
            unique case (addr)
                A_DATA:    data = drq[sel] ? words[sel] : '0;
                A_ERRFEAT: data = WORD_W'(cur.error);
                A_SCNT:    data = WORD_W'(cur.sec_cnt);
                A_SNUM:    data = WORD_W'(cur.sec_num);
                A_CYLL:    data = WORD_W'(cur.cyl_lo);
                A_CYLH:    data = WORD_W'(cur.cyl_hi);
                A_DEVHD:   data = WORD_W'(cur.dev_hd);
                A_STATCMD,
                A_ALTCTL:  data = WORD_W'(stat_vis);
                default:   err  = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/tf_pair_bank.sv
module tf_pair_bank
    import tfb_pkg::*;
#(
    parameter  int WORD_W    = 16,
    parameter  int BUF_DEPTH = 256,
    localparam int PTR_W     = $clog2(BUF_DEPTH),
    localparam int CNT_W     = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dev_present,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [3:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic              host_rvalid,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_rerr,
    input  logic              fill_we,
    input  logic              fill_dev,
    input  logic [PTR_W-1:0]  fill_addr,
    input  logic [WORD_W-1:0] fill_word,
    input  logic              eng_upd,
    input  logic              eng_dev,
    input  logic [7:0]        eng_status,
    input  logic [7:0]        eng_error,
    input  logic              eng_xfer,
    input  logic [CNT_W-1:0]  eng_words,
    output logic [1:0]        cmd_pulse,
    output logic [7:0]        cmd_code,
    output logic [7:0]        cmd_feat,
    output logic [1:0]        proto_warn
);

    task_file_t [N_DEV-1:0]       tf_arr;
    logic [N_DEV-1:0]             dev_drq;
    logic [N_DEV-1:0][WORD_W-1:0] dev_word;
    logic [N_DEV-1:0]             dev_id;
    logic                         rd_sel;
    logic [WORD_W-1:0]            mux_data;
    logic                         mux_err;
    logic                         data_rd;
    logic [WORD_W-1:0]            rdata_q;
    logic                         rerr_q, rvalid_q;
    logic [7:0]                   cmd_code_q;

    // slot 1 takes identity 1 only beside a fitted slot 0
    assign dev_id[0] = 1'b0;
    assign dev_id[1] = dev_present[0];

    assign data_rd = host_rd && (host_addr == A_DATA) && (dev_present != '0);

    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
        tfb_dev #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH)) u_dev (
            .clk        (clk),
            .rst_n      (rst_n),
            .present    (dev_present[d]),
            .my_id      (dev_id[d]),
            .wr         (host_wr),
            .addr       (host_addr),
            .wdata      (host_wdata),
            .pop        (data_rd && (rd_sel == 1'(d))),
            .fill_we    (fill_we && (fill_dev == 1'(d))),
            .fill_addr  (fill_addr),
            .fill_word  (fill_word),
            .upd        (eng_upd && (eng_dev == 1'(d))),
            .upd_status (eng_status),
            .upd_error  (eng_error),
            .xfer       (eng_xfer && (eng_dev == 1'(d))),
            .xfer_words (eng_words),
            .tf         (tf_arr[d]),
            .drq        (dev_drq[d]),
            .word       (dev_word[d]),
            .cmd_pulse  (cmd_pulse[d]),
            .warn       (proto_warn[d])
        );
    end

    tfb_read_mux #(.WORD_W(WORD_W)) u_mux (
        .present (dev_present),
        .ids     (dev_id),
        .tf      (tf_arr),
        .drq     (dev_drq),
        .words   (dev_word),
        .addr    (host_addr),
        .sel     (rd_sel),
        .data    (mux_data),
        .err     (mux_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            rerr_q     <= 1'b0;
            rvalid_q   <= 1'b0;
            cmd_code_q <= '0;
        end else begin
            rvalid_q <= host_rd;
            if (host_rd) begin
                rdata_q <= mux_data;
                rerr_q  <= mux_err;
            end
            if (host_wr && (host_addr == A_STATCMD) && (dev_present != '0)) begin
                cmd_code_q <= host_wdata;
            end
        end
    end

    assign host_rvalid = rvalid_q;
    assign host_rdata  = rdata_q;
    assign host_rerr   = rerr_q;
    assign cmd_code    = cmd_code_q;
    assign cmd_feat    = tf_arr[rd_sel].feat;

endmodule

// File: rtl/tf_pair_bank_chk.sv
module tf_pair_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  dev_present,
    input logic        host_wr,
    input logic        host_rd,
    input logic [3:0]  host_addr,
    input logic [7:0]  host_wdata,
    input logic        host_rvalid,
    input logic [15:0] host_rdata,
    input logic        host_rerr,
    input logic        eng_xfer,
    input logic        eng_dev,
    input logic [1:0]  cmd_pulse,
    input logic [1:0]  proto_warn,
    input logic [1:0]  dev_drq
);

    // R10: an errored read never carries data
    assert_err_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && host_rerr) |-> (host_rdata == 16'h0));

    // R10: with nothing fitted every read errs
    assert_no_device_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (dev_present == 2'b00)) |=> (host_rerr && host_rdata == 16'h0));

    // R6: data port with no request pending reads zero
    assert_idle_data_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 4'd0 && dev_drq == 2'b00) |=> (host_rdata == 16'h0));

    // R7: a data request only appears after a transfer is opened for that slot
    assert_drq0_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_drq[0]) |-> $past(eng_xfer && !eng_dev));
    assert_drq1_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_drq[1]) |-> $past(eng_xfer && eng_dev));

    // R8: strobes follow a command write; only fitted slots strobe
    assert_strobe_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse != 2'b00) |-> ($past(host_wr && host_addr == 4'd7)
                                  && ((cmd_pulse & ~dev_present) == 2'b00)));

    // R8: both slots strobe together only for the diagnostics command
    assert_dual_strobe_diag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse == 2'b11) |-> $past(host_wdata == 8'h90));

    // R9: warnings never follow the drive-reset command
    assert_warn_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_warn != 2'b00) |-> $past(host_wr && host_addr == 4'd7 && host_wdata != 8'h08));

endmodule

bind tf_pair_bank tf_pair_bank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_present (dev_present),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata),
    .host_rerr   (host_rerr),
    .eng_xfer    (eng_xfer),
    .eng_dev     (eng_dev),
    .cmd_pulse   (cmd_pulse),
    .proto_warn  (proto_warn),
    .dev_drq     (dev_drq)
);

// File: tb/tf_pair_bank_bench.sv
module tf_pair_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  dev_present = 2'b11;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_rvalid, host_rerr;
    logic [15:0] host_rdata;
    logic        fill_we = 1'b0, fill_dev = 1'b0;
    logic [7:0]  fill_addr = '0;
    logic [15:0] fill_word = '0;
    logic        eng_upd = 1'b0, eng_dev = 1'b0, eng_xfer = 1'b0;
    logic [7:0]  eng_status = '0, eng_error = '0;
    logic [8:0]  eng_words = '0;
    logic [1:0]  cmd_pulse, proto_warn;
    logic [7:0]  cmd_code, cmd_feat;

    int n_checks = 0;
    int n_errors = 0;
    logic [1:0]  last_pulse, last_warn;
    logic [15:0] rv;
    logic        re;

    always #4 clk = ~clk;

    tf_pair_bank u_tf_pair_bank (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] pres);
        @(negedge clk);
        dev_present = pres;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        last_pulse = cmd_pulse;
        last_warn  = proto_warn;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(posedge clk); #1;
        rv = host_rdata;
        re = host_rerr;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic fill(input logic d, input logic [7:0] a, input logic [15:0] w);
        @(negedge clk);
        fill_we = 1'b1; fill_dev = d; fill_addr = a; fill_word = w;
        @(negedge clk);
        fill_we = 1'b0;
    endtask

    task automatic eng_set(input logic d, input logic [7:0] s, input logic [7:0] e);
        @(negedge clk);
        eng_upd = 1'b1; eng_dev = d; eng_status = s; eng_error = e;
        @(negedge clk);
        eng_upd = 1'b0;
    endtask

    task automatic eng_go(input logic d, input logic [8:0] n);
        @(negedge clk);
        eng_xfer = 1'b1; eng_dev = d; eng_words = n;
        @(negedge clk);
        eng_xfer = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(2'b11);
        check("R1 cmd_pulse idle", 32'(cmd_pulse), 32'h0);
        rd(4'd7); check("R1 status after power-on", 32'(rv), 32'h40);
        rd(4'd4); check("R1 cylinder low cleared", 32'(rv), 32'h0);
        check("R1 no read error", 32'(re), 32'h0);
    endtask

    task automatic t_broadcast;
        do_reset(2'b11);
        wr(4'd4, 8'h12); wr(4'd5, 8'h34); wr(4'd1, 8'h03);
        eng_set(1'b0, 8'h41, 8'h04);
        eng_set(1'b1, 8'h50, 8'h00);
        rd(4'd4); check("R2 cyl low via slot 0", 32'(rv), 32'h12);
        rd(4'd7); check("R3 slot 0 answers with sel=0", 32'(rv), 32'h41);
        rd(4'd1); check("R12 slot 0 error", 32'(rv), 32'h04);
        wr(4'd6, 8'h10);
        rd(4'd5); check("R2 cyl high via slot 1", 32'(rv), 32'h34);
        check("R2 features reached slot 1", 32'(cmd_feat), 32'h03);
        rd(4'd7); check("R3 slot 1 answers with sel=1", 32'(rv), 32'h50);
        rd(4'd1); check("R12 slot 1 error", 32'(rv), 32'h00);
        eng_set(1'b1, 8'h59, 8'h22);
        rd(4'd7); check("R12 status bit 3 not taken from engine", 32'(rv), 32'h51);
        rd(4'd1); check("R12 error replaced", 32'(rv), 32'h22);
    endtask

    task automatic t_single;
        do_reset(2'b01);
        wr(4'd6, 8'h10); wr(4'd4, 8'h55);
        rd(4'd7); check("R4 status zero on mismatch", 32'(rv), 32'h0);
        rd(4'd8); check("R4 alt status zero on mismatch", 32'(rv), 32'h0);
        rd(4'd4); check("R3 lone slot 0 still answers", 32'(rv), 32'h55);
        do_reset(2'b10);
        rd(4'd7); check("R5 lone slot 1 has identity 0", 32'(rv), 32'h40);
        wr(4'd6, 8'h10);
        rd(4'd8); check("R5 lone slot 1 mismatches sel=1", 32'(rv), 32'h0);
        check("R3 lone slot 1 no error", 32'(re), 32'h0);
    endtask

    task automatic t_data;
        do_reset(2'b11);
        rd(4'd0); check("R6 data with request clear", 32'(rv), 32'h0);
        for (int i = 0; i < 4; i++) fill(1'b0, 8'(i), 16'hA5A0 + 16'(i));
        fill(1'b1, 8'd0, 16'h1111);
        eng_go(1'b0, 9'd3);
        rd(4'd7); check("R7 request flag set", 32'(rv), 32'h48);
        for (int i = 0; i < 3; i++) begin
            rd(4'd0); check("R7 buffer word order", 32'(rv), 32'hA5A0 + 32'(i));
        end
        rd(4'd7); check("R7 request cleared after last word", 32'(rv), 32'h40);
        rd(4'd0); check("R6 data after transfer end", 32'(rv), 32'h0);
        wr(4'd6, 8'h10);
        rd(4'd0); check("R6 slot 1 no request", 32'(rv), 32'h0);
    endtask

    task automatic t_cmd;
        do_reset(2'b11);
        wr(4'd7, 8'hEC);
        check("R8 selected slot 0 strobes", 32'(last_pulse), 32'h1);
        check("R8 command byte", 32'(cmd_code), 32'hEC);
        check("R9 no warning when idle", 32'(last_warn), 32'h0);
        wr(4'd6, 8'h10); wr(4'd7, 8'h20);
        check("R8 selected slot 1 strobes", 32'(last_pulse), 32'h2);
        wr(4'd7, 8'h90);
        check("R8 diagnostics reaches both", 32'(last_pulse), 32'h3);
        do_reset(2'b10);
        wr(4'd7, 8'h20);
        check("R8 lone slot 1 selected by sel=0", 32'(last_pulse), 32'h2);
    endtask

    task automatic t_warn;
        do_reset(2'b11);
        eng_set(1'b0, 8'hC0, 8'h00);
        wr(4'd7, 8'h20);
        check("R9 warning on busy slot 0", 32'(last_warn), 32'h1);
        wr(4'd7, 8'h08);
        check("R9 drive reset exempt", 32'(last_warn), 32'h0);
        eng_set(1'b0, 8'h40, 8'h00);
        eng_go(1'b1, 9'd2);
        wr(4'd7, 8'h30);
        check("R9 warning on data request slot 1", 32'(last_warn), 32'h2);
        check("R8 slot 0 still strobes", 32'(last_pulse), 32'h1);
    endtask

    task automatic t_srst;
        do_reset(2'b11);
        eng_go(1'b0, 9'd4);
        wr(4'd8, 8'h04);
        rd(4'd7); check("R11 busy set, request dropped", 32'(rv), 32'hC0);
        rd(4'd0); check("R11 data port quiet in reset", 32'(rv), 32'h0);
        wr(4'd8, 8'h00);
        rd(4'd7); check("R11 ready after reset ends", 32'(rv), 32'h40);
        rd(4'd1); check("R11 diagnostic code", 32'(rv), 32'h01);
        wr(4'd6, 8'h10);
        rd(4'd1); check("R11 slot 1 diagnostic code", 32'(rv), 32'h01);
    endtask

    task automatic t_absent;
        do_reset(2'b11);
        rd(4'd9);  check("R10 addr 9 data", 32'(rv), 32'h0);
        check("R10 addr 9 error", 32'(re), 32'h1);
        rd(4'd15); check("R10 addr 15 error", 32'(re), 32'h1);
        do_reset(2'b00);
        wr(4'd4, 8'h77);
        rd(4'd4); check("R10 no device data", 32'(rv), 32'h0);
        check("R10 no device error", 32'(re), 32'h1);
        wr(4'd7, 8'h90);
        check("R8 nothing fitted no strobe", 32'(last_pulse), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_broadcast();
        t_single();
        t_data();
        t_cmd();
        t_warn();
        t_srst();
        t_absent();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule